// File: doc/BRIEF.md
# Type B Tag Response Frame Serializer

This block turns a response held as a sequence of bytes into the bit stream a contactless Type B tag sends back to the reader. The output comes before any modulator, one sample per strobe. A frame opens with a long run of ones so the reader can lock its phase reference. A start-of-frame marker follows, then one ten-bit character per byte, then an end-of-frame marker. Every logical bit appears as four identical samples in a row. The caller appends the CRC to the payload beforehand; the serializer neither computes nor checks it.

A frame starts with a one-cycle `start_i` pulse while the block is idle. If `empty_i` is high with that pulse, the frame carries no characters. Otherwise bytes arrive on a valid/ready port. `in_ready_o` is high only in the gap between two characters, and a byte moves across on any clock edge where both `in_valid_i` and `in_ready_o` are high. The byte that carries `in_last_i` is the final one. The caller may hold `in_valid_i` low as long as it likes. While it does, the serializer waits and emits no strobes, so back-pressure costs time but never corrupts the stream. Each strobe on `sample_en_o` marks one valid sample on `sample_o`. With default parameters there is one strobe per `SAMPLE_DIV` clocks during each frame section. `done_o` pulses once after the last sample.

Top module: `typeb_tag_framer`

## Requirements
- R1: Each logical bit is carried by exactly four consecutive strobed samples of equal value, so a frame always has a multiple of four samples.
- R2: A frame begins with 20 logical ones (80 samples).
- R3: The ones run is followed by a start-of-frame marker of 10 logical zeros and then 2 logical ones.
- R4: Each byte becomes one character: a 0 start bit, then data bits 0 through 7 in that order (least significant first), then a 1 stop bit. A character's first sample follows the previous character's last sample with no extra bits between them.
- R5: After the character of the byte flagged `in_last_i` (or directly after the start-of-frame marker for an empty frame), the frame ends with 10 logical zeros and then 2 logical ones. A frame of n bytes therefore has 176 + 40·n samples.
- R6: `in_ready_o` is high only between characters and only while busy, and no strobe is issued while it is high. Exactly one byte is accepted per character.
- R7: `done_o` is high for exactly one cycle, the cycle after the final sample's strobe. `busy_o` is low in that cycle, and no strobe follows until the next start.
- R8: A start with `empty_i` high produces the ones run and both markers only (176 samples), and `in_ready_o` is never raised.
- R9: A `start_i` pulse while busy is ignored, and the current frame continues unchanged.
- R10: After reset and between frames, `busy_o`, `in_ready_o`, `sample_en_o` and `done_o` are low and `sample_o` rests at 1.
- R11: Within a frame section, consecutive strobes are exactly `SAMPLE_DIV` clock cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Pulse to begin a frame; used only when idle |
| empty_i | input | 1 | Sampled with `start_i`: frame carries no characters |
| in_valid_i | input | 1 | Byte on `in_data_i` is offered |
| in_data_i | input | DATA_W | Payload byte (CRC already included) |
| in_last_i | input | 1 | Offered byte is the final one of the frame |
| in_ready_o | output | 1 | Serializer can take a byte this cycle |
| sample_o | output | 1 | Current output sample |
| sample_en_o | output | 1 | Strobe: `sample_o` is a valid sample this cycle |
| busy_o | output | 1 | A frame is in progress |
| done_o | output | 1 | One-cycle pulse after the final sample |

## Verification
The checker assumes only that reset is applied at the start. It assumes nothing about input timing: a byte offered while ready is low simply waits, so no input ordering can break its properties. The stimulus keeps each byte and its last flag steady from the moment valid rises until the cycle after the handshake. It raises the last flag on exactly one byte per frame and uses `start_i` only as a single-cycle pulse, which makes the expected stream a pure function of the byte list.

// File: rtl/typeb_tx_pkg.sv
package typeb_tx_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PRE,
    PH_SOF_LO,
    PH_SOF_HI,
    PH_FETCH,
    PH_CHAR,
    PH_EOF_LO,
    PH_EOF_HI
  } phase_e;
endpackage

// File: rtl/typeb_tx_pacer.sv
// Issues one tick every DIV clocks while enabled; restarts when disabled.
module typeb_tx_pacer #(
  parameter int DIV = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!en_i || cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick_o = en_i && (cnt_q == LAST);
endmodule

// File: rtl/typeb_tx_char.sv
// Character shifter: start bit 0, data LSB first, stop bit 1.
module typeb_tx_char #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              shift_i,
  output logic              bit_o
);
  localparam int CW = DATA_W + 2;

  logic [CW-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '1;
    end else if (load_i) begin
      sh_q <= {1'b1, data_i, 1'b0};
    end else if (shift_i) begin
      sh_q <= {1'b1, sh_q[CW-1:1]};
    end
  end

  assign bit_o = sh_q[0];
endmodule

// File: rtl/typeb_tx_seq.sv
// Frame sequencer: walks the sections, counts samples per bit and bits per section.
module typeb_tx_seq
  import typeb_tx_pkg::*;
#(
  parameter int SPB         = 4,
  parameter int PRE_BITS    = 20,
  parameter int SOF_LO_BITS = 10,
  parameter int SOF_HI_BITS = 2,
  parameter int EOF_LO_BITS = 10,
  parameter int EOF_HI_BITS = 2,
  parameter int CHAR_BITS   = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic empty_i,
  input  logic tick_i,
  input  logic in_valid_i,
  input  logic in_last_i,
  input  logic char_bit_i,
  output logic emit_o,
  output logic in_ready_o,
  output logic load_o,
  output logic shift_o,
  output logic bit_o,
  output logic busy_o,
  output logic done_o
);
  localparam int RW   = (SPB > 1) ? $clog2(SPB) : 1;
  localparam int M1   = (PRE_BITS > CHAR_BITS) ? PRE_BITS : CHAR_BITS;
  localparam int M2   = (SOF_LO_BITS > EOF_LO_BITS) ? SOF_LO_BITS : EOF_LO_BITS;
  localparam int M3   = (SOF_HI_BITS > EOF_HI_BITS) ? SOF_HI_BITS : EOF_HI_BITS;
  localparam int M12  = (M1 > M2) ? M1 : M2;
  localparam int MAXB = (M12 > M3) ? M12 : M3;
  localparam int BW   = $clog2(MAXB + 1);

  phase_e        phase_q, next_ph;
  logic [RW-1:0] rep_q;
  logic [BW-1:0] bit_q;
  logic          empty_q, last_q, done_q;
  logic          bit_end, sect_end;

  function automatic logic [BW-1:0] span(phase_e p);
    case (p)
      PH_PRE:    span = BW'(PRE_BITS - 1);
      PH_SOF_LO: span = BW'(SOF_LO_BITS - 1);
      PH_SOF_HI: span = BW'(SOF_HI_BITS - 1);
      PH_CHAR:   span = BW'(CHAR_BITS - 1);
      PH_EOF_LO: span = BW'(EOF_LO_BITS - 1);
      PH_EOF_HI: span = BW'(EOF_HI_BITS - 1);
      default:   span = '0;
    endcase
  endfunction

  assign bit_end  = tick_i && (rep_q == RW'(SPB - 1));
  assign sect_end = bit_end && (bit_q == span(phase_q));

  always_comb begin
    case (phase_q)
      PH_PRE:    next_ph = PH_SOF_LO;
      PH_SOF_LO: next_ph = PH_SOF_HI;
      PH_SOF_HI: next_ph = empty_q ? PH_EOF_LO : PH_FETCH;
      PH_CHAR:   next_ph = last_q ? PH_EOF_LO : PH_FETCH;
      PH_EOF_LO: next_ph = PH_EOF_HI;
      default:   next_ph = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      rep_q   <= '0;
      bit_q   <= '0;
      empty_q <= 1'b0;
      last_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (phase_q)
        PH_IDLE: begin
          if (start_i) begin
            phase_q <= PH_PRE;
            empty_q <= empty_i;
            rep_q   <= '0;
            bit_q   <= '0;
          end
        end
        PH_FETCH: begin
          if (in_valid_i) begin
            phase_q <= PH_CHAR;
            last_q  <= in_last_i;
          end
        end
        default: begin
          if (tick_i) begin
            rep_q <= bit_end ? '0 : rep_q + 1'b1;
            if (sect_end) begin
              bit_q   <= '0;
              phase_q <= next_ph;
              if (phase_q == PH_EOF_HI) done_q <= 1'b1;
            end else if (bit_end) begin
              bit_q <= bit_q + 1'b1;
            end
          end
        end
      endcase
    end
  end

  always_comb begin
    case (phase_q)
      PH_SOF_LO, PH_EOF_LO: bit_o = 1'b0;
      PH_CHAR:              bit_o = char_bit_i;
      default:              bit_o = 1'b1;
    endcase
  end

  assign emit_o     = (phase_q != PH_IDLE) && (phase_q != PH_FETCH);
  assign in_ready_o = (phase_q == PH_FETCH);
  assign load_o     = in_ready_o && in_valid_i;
  assign shift_o    = (phase_q == PH_CHAR) && bit_end;
  assign busy_o     = (phase_q != PH_IDLE);
  assign done_o     = done_q;
endmodule

// File: rtl/typeb_tag_framer.sv
module typeb_tag_framer #(
  parameter int DATA_W      = 8,
  parameter int SPB         = 4,
  parameter int SAMPLE_DIV  = 1,
  parameter int PRE_BITS    = 20,
  parameter int SOF_LO_BITS = 10,
  parameter int SOF_HI_BITS = 2,
  parameter int EOF_LO_BITS = 10,
  parameter int EOF_HI_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              empty_i,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_last_i,
  output logic              in_ready_o,
  output logic              sample_o,
  output logic              sample_en_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int CHAR_BITS = DATA_W + 2;

  logic emit, tick, load, shift, char_bit;

  typeb_tx_pacer #(.DIV(SAMPLE_DIV)) u_pacer (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (emit),
    .tick_o (tick)
  );

  typeb_tx_char #(.DATA_W(DATA_W)) u_char (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load),
    .data_i  (in_data_i),
    .shift_i (shift),
    .bit_o   (char_bit)
  );

  typeb_tx_seq #(
    .SPB(SPB), .PRE_BITS(PRE_BITS), .SOF_LO_BITS(SOF_LO_BITS),
    .SOF_HI_BITS(SOF_HI_BITS), .EOF_LO_BITS(EOF_LO_BITS),
    .EOF_HI_BITS(EOF_HI_BITS), .CHAR_BITS(CHAR_BITS)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .empty_i    (empty_i),
    .tick_i     (tick),
    .in_valid_i (in_valid_i),
    .in_last_i  (in_last_i),
    .char_bit_i (char_bit),
    .emit_o     (emit),
    .in_ready_o (in_ready_o),
    .load_o     (load),
    .shift_o    (shift),
    .bit_o      (sample_o),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  assign sample_en_o = tick;
endmodule

// File: rtl/typeb_tag_framer_chk.sv
module typeb_tag_framer_chk #(
  parameter int SPB = 4
) (
  input logic clk,
  input logic rst_n,
  input logic in_ready_o,
  input logic sample_o,
  input logic sample_en_o,
  input logic busy_o,
  input logic done_o
);
  localparam int GW = (SPB > 1) ? $clog2(SPB) : 1;

  logic [GW-1:0] grp_q;
  logic          prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_q  <= '0;
      prev_q <= 1'b1;
    end else if (!busy_o) begin
      grp_q <= '0;
    end else if (sample_en_o) begin
      grp_q  <= (grp_q == GW'(SPB - 1)) ? '0 : grp_q + 1'b1;
      prev_q <= sample_o;
    end
  end

  assert_sample_repeat_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en_o && grp_q != '0) |-> (sample_o == prev_q));

  assert_ready_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready_o |-> busy_o);

  assert_ready_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready_o |-> !sample_en_o);

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_after_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

  assert_busy_ends_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (busy_o || done_o));

  assert_idle_line_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (sample_o && !sample_en_o && !in_ready_o));
endmodule

bind typeb_tag_framer typeb_tag_framer_chk #(.SPB(SPB)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_ready_o  (in_ready_o),
  .sample_o    (sample_o),
  .sample_en_o (sample_en_o),
  .busy_o      (busy_o),
  .done_o      (done_o)
);

// File: tb/typeb_tag_framer_tb.sv
module typeb_tag_framer_tb;
  localparam int SPB  = 4;
  localparam int DIV  = 2;
  localparam int NV   = 6;
  localparam int MAXS = 512;

  localparam logic [31:0] VDATA [NV] = '{32'h0000_00A5, 32'h0000_FF00, 32'h000D_8250,
                                         32'hAA55_8001, 32'h0000_0000, 32'h0000_7FFE};
  localparam int VLEN [NV] = '{1, 2, 3, 4, 1, 2};
  localparam int VGAP [NV] = '{0, 0, 3, 0, 5, 1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, empty_i = 1'b0, in_valid_i = 1'b0, in_last_i = 1'b0;
  logic [7:0] in_data_i = 8'h00;
  logic in_ready_o, sample_o, sample_en_o, busy_o, done_o;

  always #10 clk = ~clk;

  typeb_tag_framer #(.SAMPLE_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .empty_i(empty_i),
    .in_valid_i(in_valid_i), .in_data_i(in_data_i), .in_last_i(in_last_i),
    .in_ready_o(in_ready_o), .sample_o(sample_o), .sample_en_o(sample_en_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  int n_run = 0, n_fail = 0;
  logic cap [MAXS];
  logic eb [MAXS];
  int ncap, nb, clash, hs, rdy_seen, done_cnt, cnt_at_done, cyc, s0, s1;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (sample_en_o) begin
        if (ncap < MAXS) cap[ncap] = sample_o;
        if (ncap == 0) s0 = cyc;
        if (ncap == 1) s1 = cyc;
        ncap++;
      end
      if (in_ready_o && sample_en_o) clash++;
      if (in_ready_o) rdy_seen++;
      if (in_ready_o && in_valid_i) hs++;
      if (done_o) begin done_cnt++; cnt_at_done = ncap; end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input logic v, input int n);
    for (int i = 0; i < n; i++) begin eb[nb] = v; nb++; end
  endtask

  task automatic build(input int len, input logic [31:0] d);
    nb = 0;
    push(1'b1, 20); push(1'b0, 10); push(1'b1, 2);
    for (int b = 0; b < len; b++) begin
      push(1'b0, 1);
      for (int k = 0; k < 8; k++) push(d[8*b+k], 1);
      push(1'b1, 1);
    end
    push(1'b0, 10); push(1'b1, 2);
  endtask

  task automatic seg(input string req, input int a, input int b);
    int bad;
    bad = -1;
    for (int i = a; i < b; i++)
      if (bad < 0 && (i >= ncap || cap[i] !== eb[i/SPB])) bad = i;
    if (bad < 0) check(1'b1, req, 0, 0);
    else check(1'b0, req, (bad < ncap) ? int'(cap[bad]) : -1, int'(eb[bad/SPB]));
  endtask

  task automatic feed(input int len, input logic [31:0] d, input int gap);
    for (int b = 0; b < len; b++) begin
      repeat (gap) @(posedge clk);
      #2 in_valid_i = 1'b1; in_data_i = d[8*b +: 8]; in_last_i = (b == len - 1);
      for (int t = 0; t < 4000; t++) begin
        @(negedge clk);
        if (in_ready_o) break;
      end
      @(posedge clk);
      #2 in_valid_i = 1'b0; in_last_i = 1'b0;
    end
  endtask

  task automatic run_frame(input int len, input logic [31:0] d, input int gap,
                           input bit empty, input bit restart);
    int exp_n;
    ncap = 0; clash = 0; hs = 0; rdy_seen = 0; done_cnt = 0; cnt_at_done = -1;
    build(len, d);
    exp_n = nb * SPB;
    @(posedge clk); #2 start_i = 1'b1; empty_i = empty;
    @(posedge clk); #2 start_i = 1'b0; empty_i = 1'b0;
    fork
      feed(len, d, gap);
      begin
        if (restart) begin
          repeat (30) @(posedge clk);
          #2 start_i = 1'b1;
          @(posedge clk); #2 start_i = 1'b0;
        end
      end
      begin
        for (int t = 0; t < 8000 && done_cnt == 0; t++) @(posedge clk);
      end
    join
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(done_cnt != 0, "R7 frame finished before watchdog", done_cnt, 1);
    check((ncap % SPB) == 0, "R1 sample count multiple of four", ncap, exp_n);
    begin
      int badg;
      badg = -1;
      for (int g = 0; g + SPB <= ncap && g + SPB <= MAXS; g += SPB)
        for (int k = 1; k < SPB; k++)
          if (badg < 0 && cap[g+k] !== cap[g]) badg = g + k;
      check(badg < 0, "R1 four identical samples per bit", badg, -1);
    end
    seg("R2 ones run", 0, 80);
    seg("R3 start-of-frame marker", 80, 128);
    seg("R4 characters", 128, 128 + 40 * len);
    seg("R5 end-of-frame marker", 128 + 40 * len, exp_n);
    check(ncap == exp_n, "R5 total samples", ncap, exp_n);
    check(cnt_at_done == exp_n, "R7 done right after final sample", cnt_at_done, exp_n);
    check(done_cnt == 1, "R7 single done pulse", done_cnt, 1);
    check(clash == 0, "R6 no strobe while ready", clash, 0);
    check(hs == len, "R6 one byte per character", hs, len);
    check(!busy_o, "R7 idle after done", int'(busy_o), 0);
    check(s1 - s0 == DIV, "R11 strobe spacing", s1 - s0, DIV);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(!busy_o && !in_ready_o && !sample_en_o && !done_o, "R10 outputs low after reset",
          {busy_o, in_ready_o, sample_en_o, done_o}, 0);
    check(sample_o == 1'b1, "R10 line rests high", int'(sample_o), 1);

    for (int v = 0; v < NV; v++) run_frame(VLEN[v], VDATA[v], VGAP[v], 1'b0, 1'b0);

    // R8 empty frame
    run_frame(0, 32'h0, 0, 1'b1, 1'b0);
    check(rdy_seen == 0, "R8 ready never raised for empty frame", rdy_seen, 0);

    // R9 start while busy is ignored (empty frame, second start asks for data)
    run_frame(0, 32'h0, 0, 1'b1, 1'b1);
    check(rdy_seen == 0, "R9 restart ignored, no fetch", rdy_seen, 0);

    // R10 between frames
    @(negedge clk);
    check(!busy_o && !sample_en_o && sample_o, "R10 idle between frames",
          {busy_o, sample_en_o, sample_o}, 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule